// File: doc/BRIEF.md
# Output Port Set/Clear Register

This block holds a general-purpose output register whose bits change only through masked commands: a set command turns on every bit whose position carries a one in the accompanying data word, and a clear command turns those bits off. Every other bit keeps its value. Several command lanes can present commands in the same cycle. All set masks are merged, all clear masks are merged, and the clear is applied after the set.

Each output pin has its own source selector. The low pins carry the active-low request-to-send levels for the serial channels. When their select is on, each of them passes a level supplied by the channel's mode and command logic. The upper pins are each chosen by a configuration bit, either from the register or from an alternate function signal such as the counter/timer output. Whenever a pin is fed from the register, its level is the inverse of the register bit, so a set bit drives the pin low. The register contents can also be read through a read-only view.

Top module: `outport_ctl`

## Requirements
- R1: While reset is asserted, the register holds all zeros, and every pin whose source is the register reads high.
- R2: A lane with `cmd_valid` high and command code 0xE sets to one every register bit that has a one in its data word. All other bits are unchanged. The new value is visible on the cycle after the command edge.
- R3: A lane with `cmd_valid` high and command code 0xF clears to zero every register bit that has a one in its data word. All other bits are unchanged.
- R4: A lane whose `cmd_valid` is low, or whose code is neither 0xE nor 0xF, leaves the register unchanged.
- R5: A pin fed from the register drives the logical inverse of its register bit.
- R6: For pin k+2, bit k of `alt_sel` picks the source: 0 picks the register and 1 picks `alt_in[k]`. Pin 3 (`alt_in[1]`) is the counter/timer output.
- R7: For pin k with k < 2, bit k of `rts_sel` picks the source: 0 picks the register and 1 picks `rts_n_in[k]`. These are the active-low request-to-send levels of channels A and B.
- R8: When set and clear commands reach the same bit in one cycle, from any lanes, the clear wins. Bits touched by only one of the commands take that command's effect.
- R9: `reg_view` always shows the current register value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 2 | Per-lane command strobe |
| cmd_code | input | 8 | Per-lane 4-bit command code; lane n at bits [4n+3:4n] |
| cmd_data | input | 16 | Per-lane 8-bit bit mask; lane n at bits [8n+7:8n] |
| alt_sel | input | 6 | Source select for pins 2 to 7 (1 = alternate) |
| alt_in | input | 6 | Alternate function levels for pins 2 to 7 |
| rts_sel | input | 2 | Source select for pins 0 and 1 (1 = request-to-send level) |
| rts_n_in | input | 2 | Active-low request-to-send levels for channels A and B |
| pin_out | output | 8 | Output pin levels |
| reg_view | output | 8 | Read-only view of the register |

## Verification
The register properties compare each command's merged masks with the register on the following edge. They assume the command inputs are idle while reset is held, so the first edge after release sees no stale mask. The pin properties assume the source selects stay put across the edge that follows a command. The stimulus therefore changes the selects and commands only at falling edges, holds them for a full cycle, and keeps `cmd_valid` low throughout reset.

// File: rtl/outport_pkg.sv
package outport_pkg;
   localparam int unsigned CMD_W    = 4;
   localparam logic [CMD_W-1:0] CMD_BITSET = 4'hE;
   localparam logic [CMD_W-1:0] CMD_BITCLR = 4'hF;

   typedef enum logic {
      SRC_REG = 1'b0,
      SRC_ALT = 1'b1
   } pin_src_e;
endpackage

// File: rtl/outport_cmd_decode.sv
module outport_cmd_decode
   import outport_pkg::*;
#(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned CODE_W = CMD_W
) (
   input  logic              valid,
   input  logic [CODE_W-1:0] code,
   input  logic [WIDTH-1:0]  data,
   output logic [WIDTH-1:0]  set_mask,
   output logic [WIDTH-1:0]  clr_mask
);
   logic is_set;
   logic is_clr;

   always_comb begin
      is_set   = valid && (code == CODE_W'(CMD_BITSET));
      is_clr   = valid && (code == CODE_W'(CMD_BITCLR));
      set_mask = is_set ? data : '0;
      clr_mask = is_clr ? data : '0;
   end
endmodule

// File: rtl/outport_bitreg.sv
module outport_bitreg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_mask,
   input  logic [WIDTH-1:0] clr_mask,
   output logic [WIDTH-1:0] reg_q
);
   logic [WIDTH-1:0] reg_d;

   always_comb begin
      reg_d = (reg_q | set_mask) & ~clr_mask;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reg_q <= '0;
      else        reg_q <= reg_d;
   end

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((reg_q & $past(set_mask & ~clr_mask)) == $past(set_mask & ~clr_mask)))
      else $error("set bits not applied"); // R2
   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((reg_q & $past(clr_mask)) == '0))
      else $error("cleared bits still set"); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (set_mask == '0 && clr_mask == '0) |=> $stable(reg_q))
      else $error("register moved without command"); // R4
   AST_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((reg_q & ~$past(set_mask | clr_mask)) == ($past(reg_q) & ~$past(set_mask | clr_mask))))
      else $error("unmasked bit changed"); // R3
endmodule

// File: rtl/outport_pin_mux.sv
module outport_pin_mux
   import outport_pkg::*;
#(
   parameter int unsigned WIDTH    = 8,
   parameter int unsigned RTS_PINS = 2,
   localparam int unsigned ALT_W   = WIDTH - RTS_PINS
) (
   input  logic [WIDTH-1:0]    reg_q,
   input  logic [ALT_W-1:0]    alt_sel,
   input  logic [ALT_W-1:0]    alt_in,
   input  logic [RTS_PINS-1:0] rts_sel,
   input  logic [RTS_PINS-1:0] rts_n_in,
   output logic [WIDTH-1:0]    pin_out,
   output logic [WIDTH-1:0]    src_is_reg
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      pin_src_e src;
      logic     alt_lvl;
      if (i < RTS_PINS) begin : g_rts
         assign src     = pin_src_e'(rts_sel[i]);
         assign alt_lvl = rts_n_in[i];
      end else begin : g_gen
         assign src     = pin_src_e'(alt_sel[i-RTS_PINS]);
         assign alt_lvl = alt_in[i-RTS_PINS];
      end
      assign src_is_reg[i] = (src == SRC_REG);
      assign pin_out[i]    = (src == SRC_REG) ? ~reg_q[i] : alt_lvl;
   end
endmodule

// File: rtl/outport_ctl.sv
module outport_ctl
   import outport_pkg::*;
#(
   parameter int unsigned WIDTH     = 8,
   parameter int unsigned NUM_LANES = 2,
   parameter int unsigned RTS_PINS  = 2,
   localparam int unsigned ALT_W    = WIDTH - RTS_PINS
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_LANES-1:0]       cmd_valid,
   input  logic [NUM_LANES*CMD_W-1:0] cmd_code,
   input  logic [NUM_LANES*WIDTH-1:0] cmd_data,
   input  logic [ALT_W-1:0]           alt_sel,
   input  logic [ALT_W-1:0]           alt_in,
   input  logic [RTS_PINS-1:0]        rts_sel,
   input  logic [RTS_PINS-1:0]        rts_n_in,
   output logic [WIDTH-1:0]           pin_out,
   output logic [WIDTH-1:0]           reg_view
);
   if (WIDTH <= RTS_PINS) begin : g_bad_width
      $error("WIDTH must exceed RTS_PINS");
   end
   if (NUM_LANES < 1) begin : g_bad_lanes
      $error("NUM_LANES must be at least 1");
   end

   logic [WIDTH-1:0] lane_set [NUM_LANES];
   logic [WIDTH-1:0] lane_clr [NUM_LANES];
   logic [WIDTH-1:0] set_all;
   logic [WIDTH-1:0] clr_all;
   logic [WIDTH-1:0] reg_q;
   logic [WIDTH-1:0] src_is_reg;

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      outport_cmd_decode #(.WIDTH(WIDTH), .CODE_W(CMD_W)) u_dec (
         .valid    (cmd_valid[l]),
         .code     (cmd_code[l*CMD_W +: CMD_W]),
         .data     (cmd_data[l*WIDTH +: WIDTH]),
         .set_mask (lane_set[l]),
         .clr_mask (lane_clr[l])
      );
   end

   always_comb begin
      set_all = '0;
      clr_all = '0;
      for (int l = 0; l < NUM_LANES; l++) begin
         set_all = set_all | lane_set[l];
         clr_all = clr_all | lane_clr[l];
      end
   end

   outport_bitreg #(.WIDTH(WIDTH)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_mask (set_all),
      .clr_mask (clr_all),
      .reg_q    (reg_q)
   );

   outport_pin_mux #(.WIDTH(WIDTH), .RTS_PINS(RTS_PINS)) u_mux (
      .reg_q      (reg_q),
      .alt_sel    (alt_sel),
      .alt_in     (alt_in),
      .rts_sel    (rts_sel),
      .rts_n_in   (rts_n_in),
      .pin_out    (pin_out),
      .src_is_reg (src_is_reg)
   );

   assign reg_view = reg_q;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin_chk
      AST_PIN_LOW_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (set_all[i] && !clr_all[i]) |=> (!src_is_reg[i] || !pin_out[i]))
         else $error("pin not driven low after set"); // R5
      AST_PIN_HIGH_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
         clr_all[i] |=> (!src_is_reg[i] || pin_out[i]))
         else $error("pin not driven high after clear"); // R5
   end
endmodule

// File: tb/outport_ctl_bench.sv
module outport_ctl_bench;
   localparam int W  = 8;
   localparam int L  = 2;
   localparam int CW = 4;
   localparam int RP = 2;
   localparam int AW = W - RP;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst_n;
   logic [L-1:0]  cmd_valid;
   logic [L*CW-1:0] cmd_code;
   logic [L*W-1:0]  cmd_data;
   logic [AW-1:0] alt_sel, alt_in;
   logic [RP-1:0] rts_sel, rts_n_in;
   logic [W-1:0]  pin_out, reg_view;

   outport_ctl u_outport_ctl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_data(cmd_data), .alt_sel(alt_sel), .alt_in(alt_in),
      .rts_sel(rts_sel), .rts_n_in(rts_n_in), .pin_out(pin_out), .reg_view(reg_view)
   );

   typedef struct {
      logic [W-1:0] pins;
      logic [W-1:0] view;
      string        req;
   } exp_t;

   exp_t         sb[$];
   exp_t         cur;
   int           checks = 0;
   int           errors = 0;
   logic [W-1:0] mdl;
   bit           done = 0;

   task automatic cmd(input int lane, input logic [3:0] code, input logic [7:0] data);
      cmd_valid[lane]          = 1'b1;
      cmd_code[lane*CW +: CW]  = code;
      cmd_data[lane*W +: W]    = data;
   endtask

   // Driver: model the expected result of the inputs now applied, push it, advance one cycle.
   task automatic step(input string req);
      logic [W-1:0] s, c, p;
      s = '0;
      c = '0;
      for (int l = 0; l < L; l++) begin
         if (cmd_valid[l]) begin
            if (cmd_code[l*CW +: CW] == 4'hE) s = s | cmd_data[l*W +: W];
            else if (cmd_code[l*CW +: CW] == 4'hF) c = c | cmd_data[l*W +: W];
         end
      end
      mdl = (mdl | s) & ~c;
      for (int i = 0; i < W; i++) begin
         if (i < RP) p[i] = rts_sel[i] ? rts_n_in[i] : ~mdl[i];
         else        p[i] = alt_sel[i-RP] ? alt_in[i-RP] : ~mdl[i];
      end
      sb.push_back('{p, mdl, req});
      @(posedge clk);
      @(negedge clk);
      cmd_valid = '0;
   endtask

   // Monitor: compare one cycle's outputs just after the edge.
   always @(posedge clk) begin
      #1;
      if (sb.size() > 0) begin
         cur = sb.pop_front();
         checks += 2;
         if (pin_out !== cur.pins) begin
            errors++;
            $display("FAIL %s pin_out act=%h exp=%h", cur.req, pin_out, cur.pins);
         end
         if (reg_view !== cur.view) begin
            errors++;
            $display("FAIL %s R9 reg_view act=%h exp=%h", cur.req, reg_view, cur.view);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired act=running exp=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cmd_valid = '0; cmd_code = '0; cmd_data = '0;
      alt_sel = '0; alt_in = '0; rts_sel = '0; rts_n_in = '0;
      mdl = '0;
      repeat (3) @(negedge clk);
      checks++;
      if (pin_out !== 8'hFF || reg_view !== 8'h00) begin
         errors++;
         $display("FAIL R1 reset act=%h/%h exp=ff/00", pin_out, reg_view);
      end
      rst_n = 1'b1;
      @(negedge clk);

      cmd(0, 4'hE, 8'h20);                    step("R2 R5 set bit5");          // 20, DF
      cmd(1, 4'hE, 8'h0F);                    step("R2 set low nibble");       // 2F
      cmd(0, 4'hF, 8'h05);                    step("R3 clear bits 0,2");       // 2A
      cmd(0, 4'h3, 8'hFF);                    step("R4 other code ignored");   // 2A
      cmd(1, 4'hF, 8'hFF); cmd_valid[1] = 1'b0; step("R4 strobe low ignored"); // 2A
      step("R9 idle hold");
      cmd(0, 4'hE, 8'hFF); cmd(1, 4'hF, 8'h0F); step("R8 clear wins");        // F0
      cmd(1, 4'hE, 8'h0F); cmd(0, 4'hF, 8'hF0); step("R8 split lanes");       // 0F
      cmd(0, 4'hE, 8'h03); cmd(1, 4'hE, 8'hC0); step("R2 two set lanes");     // CF
      alt_sel = 6'b000010; alt_in = 6'b000010; step("R6 pin3 counter output"); // 38
      alt_sel = 6'b111111; alt_in = 6'b101001; step("R6 all alternate");       // A4
      rts_sel = 2'b11; rts_n_in = 2'b10;        step("R7 request-to-send");     // A6
      rts_sel = 2'b01; rts_n_in = 2'b00; alt_sel = '0;
      cmd(0, 4'hF, 8'hFF);                    step("R5 R7 clear all");         // FE

      @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule